// File: doc/BRIEF.md
# SPI Interrupt Status and Ready-Edge Logic

This block is the interrupt and status layer placed beside an SPI serial engine. It catches one-cycle event pulses from the engine (transfer complete, transmit FIFO empty, transmit done, receive overflow, transmit underflow). It also watches three pins: a dedicated ready input, the MISO line and the active-low chip select. Each detected event is held in a sticky status word until software writes 1 to that bit. A per-source enable word masks the status, and the result drives one registered interrupt line.

The ready-edge source comes from a two-bit flow-control mode field. Mode `10` watches the ready pin, mode `11` watches MISO, and modes `00`/`01` turn the source off. A polarity bit picks the rising or the falling edge. Chip-select edges are recorded only when their enable is set and the serial engine reports slave mode together with continuous mode. The register port is a plain single-cycle write and combinational read, with no valid/ready handshake. It carries no data stream, so no back-pressure applies. Accesses are never stalled.

Top module: `spi_irq_status`

## Requirements
- R1: After reset the status word, the enable word, the flow-control word and `irq` are all 0.
- R2: A one-cycle engine pulse sets its status bit on the next clock edge: transfer complete bit 1, transmit FIFO empty bit 2, transmit done bit 3, receive overflow bit 4, transmit underflow bit 5.
- R3: Status bits are sticky. Writing address 0 clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the bit stays set.
- R5: With flow mode (address 2, bits [1:0]) equal to `10`, an active edge on `rdy_pin` sets status bit 15. Flow bit 4 = 1 makes the rising edge active and 0 the falling edge. MISO is ignored in this mode. The bit is set SYNC_STAGES+1 clocks after the pin changes.
- R6: With flow mode `11`, an active edge on `miso` sets status bit 15 and `rdy_pin` is ignored.
- R7: With flow mode `00` or `01`, status bit 15 reads 0 whatever the pins do, including a bit left set from an earlier mode.
- R8: A falling edge on `cs_n` sets status bit 14 and a rising edge sets bit 13, only when enable bit 8, `slave_mode` and `cont_mode` are all 1. Otherwise chip-select edges have no effect.
- R9: The enable word at address 1 holds transmit-empty at bit 14, transfer-complete at 13, transmit-done at 12, ready-edge at 11, receive-overflow at 10, transmit-underflow at 9 and chip-select at 8. All other bits read 0.
- R10: `irq` is a register holding the OR of every status bit ANDed with its enable bit (bit 8 enables both 13 and 14). It rises one clock after a gated bit sets and falls one clock after the last gated bit clears.
- R11: The flow-control word keeps only bits [1:0] and 4. The other bits read 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 flow control |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| slave_mode | input | 1 | Engine is in slave mode |
| cont_mode | input | 1 | Engine is in continuous mode |
| ev_xfr_done | input | 1 | Transfer complete pulse |
| ev_tx_empty | input | 1 | Transmit FIFO empty pulse |
| ev_tx_done | input | 1 | Transmit done pulse |
| ev_rx_ovf | input | 1 | Receive overflow pulse |
| ev_tx_unf | input | 1 | Transmit underflow pulse |
| rdy_pin | input | 1 | Asynchronous ready input |
| miso | input | 1 | Asynchronous MISO line |
| cs_n | input | 1 | Asynchronous active-low chip select |
| irq | output | 1 | Registered interrupt request |

## Verification
A sticky bit that is lost or never set shows up on the next status read, one clock after the event. Through the enable gating it also shows as a missing or stuck `irq` edge one clock after that. A synchronizer or edge selector that is wrong moves the ready or chip-select bit to a different clock or onto the wrong bit. The bench therefore toggles each pin in every mode and polarity and reads status after the exact synchronizer latency. A wrong enable decode shows up as `irq` asserting for the wrong source, so each event pulse is paired with matching and non-matching enables.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int DW = 16;

  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_FLOW = 2'd2;

  localparam int ST_XFR  = 1;
  localparam int ST_TXE  = 2;
  localparam int ST_TXD  = 3;
  localparam int ST_OVF  = 4;
  localparam int ST_UNF  = 5;
  localparam int ST_CSR  = 13;
  localparam int ST_CSF  = 14;
  localparam int ST_RDY  = 15;

  localparam int EN_TXE  = 14;
  localparam int EN_XFR  = 13;
  localparam int EN_TXD  = 12;
  localparam int EN_RDY  = 11;
  localparam int EN_OVF  = 10;
  localparam int EN_UNF  = 9;
  localparam int EN_CS   = 8;

  localparam logic [DW-1:0] EN_MASK   = 16'h7F00;
  localparam logic [DW-1:0] FLOW_MASK = 16'h0013;
  localparam int FL_POL = 4;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  localparam int CH = STAGES + 1;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic [CH-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[CH-2:0], din[i]};
    end
    assign rise[i] =  sh[CH-2] & ~sh[CH-1];
    assign fall[i] = ~sh[CH-2] &  sh[CH-1];
  end
endmodule

// File: rtl/spi_sticky_bits.sv
module spi_sticky_bits #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_v) | set_v;
  end

  // R3: a set bit that is not cleared stays set
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(q & ~clr_v)) |=> ((q & $past(q & ~clr_v)) == $past(q & ~clr_v)));

  // R4: an event beats a simultaneous clear
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/spi_irq_cfg.sv
module spi_irq_cfg
  import spi_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] flow_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flow_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_EN)   en_q   <= reg_wdata & EN_MASK;
      if (reg_addr == A_FLOW) flow_q <= reg_wdata & FLOW_MASK;
    end
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          slave_mode,
  input  logic          cont_mode,
  input  logic          ev_xfr_done,
  input  logic          ev_tx_empty,
  input  logic          ev_tx_done,
  input  logic          ev_rx_ovf,
  input  logic          ev_tx_unf,
  input  logic          rdy_pin,
  input  logic          miso,
  input  logic          cs_n,
  output logic          irq
);
  localparam int L_RDY = 0;
  localparam int L_MSO = 1;
  localparam int L_CS  = 2;

  logic [DW-1:0] st_q, set_v, clr_v, en_q, flow_q, gate_v;
  logic [2:0]    rise, fall;
  logic          src_on, rdy_edge, cs_ok;

  spi_edge_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .din({cs_n, miso, rdy_pin}),
    .rise(rise), .fall(fall)
  );

  spi_irq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en_q(en_q), .flow_q(flow_q)
  );

  assign src_on = flow_q[1];
  assign cs_ok  = en_q[EN_CS] & slave_mode & cont_mode;

  always_comb begin
    if (flow_q[0]) rdy_edge = flow_q[FL_POL] ? rise[L_MSO] : fall[L_MSO];
    else           rdy_edge = flow_q[FL_POL] ? rise[L_RDY] : fall[L_RDY];
  end

  always_comb begin
    set_v         = '0;
    set_v[ST_XFR] = ev_xfr_done;
    set_v[ST_TXE] = ev_tx_empty;
    set_v[ST_TXD] = ev_tx_done;
    set_v[ST_OVF] = ev_rx_ovf;
    set_v[ST_UNF] = ev_tx_unf;
    set_v[ST_CSF] = cs_ok & fall[L_CS];
    set_v[ST_CSR] = cs_ok & rise[L_CS];
    set_v[ST_RDY] = src_on & rdy_edge;
  end

  always_comb begin
    clr_v = (reg_wr && reg_addr == A_STAT) ? reg_wdata : '0;
    clr_v[ST_RDY] = clr_v[ST_RDY] | ~src_on;
  end

  spi_sticky_bits #(.W(DW)) u_st (
    .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .q(st_q)
  );

  always_comb begin
    gate_v         = '0;
    gate_v[ST_XFR] = en_q[EN_XFR];
    gate_v[ST_TXE] = en_q[EN_TXE];
    gate_v[ST_TXD] = en_q[EN_TXD];
    gate_v[ST_OVF] = en_q[EN_OVF];
    gate_v[ST_UNF] = en_q[EN_UNF];
    gate_v[ST_CSF] = en_q[EN_CS];
    gate_v[ST_CSR] = en_q[EN_CS];
    gate_v[ST_RDY] = en_q[EN_RDY];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(st_q & gate_v);
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = src_on ? st_q : {1'b0, st_q[DW-2:0]};
      A_EN:    reg_rdata = en_q;
      A_FLOW:  reg_rdata = flow_q;
      default: reg_rdata = '0;
    endcase
  end

  // R7: ready-edge bit is empty one clock after the source is off
  assert_rdy_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !src_on |=> !st_q[ST_RDY]);

  // R8: unqualified chip-select edges leave both bits alone
  assert_cs_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_ok && !st_q[ST_CSR] && !st_q[ST_CSF]) |=> (!st_q[ST_CSR] && !st_q[ST_CSF]));

  // R10: interrupt only follows a pending status bit
  assert_irq_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|st_q));

  assert_irq_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(|st_q) |=> !irq);
endmodule

// File: tb/sim_spi_irq_status.sv
`timescale 1ns/1ps
module sim_spi_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        slave_mode = 1'b0, cont_mode = 1'b0;
  logic        ev_xfr_done = 1'b0, ev_tx_empty = 1'b0, ev_tx_done = 1'b0;
  logic        ev_rx_ovf = 1'b0, ev_tx_unf = 1'b0;
  logic        rdy_pin = 1'b0, miso = 1'b0, cs_n = 1'b1;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  spi_irq_status u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slave_mode(slave_mode),
    .cont_mode(cont_mode), .ev_xfr_done(ev_xfr_done), .ev_tx_empty(ev_tx_empty),
    .ev_tx_done(ev_tx_done), .ev_rx_ovf(ev_rx_ovf), .ev_tx_unf(ev_tx_unf),
    .rdy_pin(rdy_pin), .miso(miso), .cs_n(cs_n), .irq(irq)
  );

  // {events[4:0] = xfr,txe,txd,ovf,unf ; enable ; expected status ; expected irq}
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {5'b10000, 16'h0000, 16'h0002, 1'b0},
    {5'b10000, 16'h2000, 16'h0002, 1'b1},
    {5'b01000, 16'h4000, 16'h0004, 1'b1},
    {5'b00100, 16'h2000, 16'h0008, 1'b0},
    {5'b00100, 16'h1000, 16'h0008, 1'b1},
    {5'b00010, 16'h0400, 16'h0010, 1'b1},
    {5'b00001, 16'h0200, 16'h0020, 1'b1},
    {5'b11111, 16'h0000, 16'h003E, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [4:0] e);
    {ev_xfr_done, ev_tx_empty, ev_tx_done, ev_rx_ovf, ev_tx_unf} = e;
    @(negedge clk);
    {ev_xfr_done, ev_tx_empty, ev_tx_done, ev_rx_ovf, ev_tx_unf} = 5'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 status", d, 16'h0);
    rd(2'd1, d); chk("R1 enable", d, 16'h0);
    rd(2'd2, d); chk("R1 flow", d, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 / R10 vector table
    for (int i = 0; i < NV; i++) begin
      wr(2'd1, VEC[i][32:17]);
      pulse(VEC[i][37:33]);
      rd(2'd0, d); chk("R2 status", d, VEC[i][16:1]);
      @(negedge clk);
      chk("R10 irq", {15'b0, irq}, {15'b0, VEC[i][0]});
      wr(2'd0, 16'hFFFF);
      rd(2'd0, d); chk("R3 cleared", d, 16'h0);
      @(negedge clk);
    end

    // R9 enable layout
    wr(2'd1, 16'hFFFF); rd(2'd1, d); chk("R9 enable mask", d, 16'h7F00);
    wr(2'd1, 16'h0000);
    // R11 flow layout and unused address
    wr(2'd2, 16'hFFFF); rd(2'd2, d); chk("R11 flow mask", d, 16'h0013);
    rd(2'd3, d); chk("R11 addr3", d, 16'h0);
    wr(2'd2, 16'h0000);

    // R3 write-0 and partial clear
    pulse(5'b10000);
    wr(2'd0, 16'h0000); rd(2'd0, d); chk("R3 write0", d, 16'h0002);
    wr(2'd0, 16'h0004); rd(2'd0, d); chk("R3 other bit", d, 16'h0002);
    wr(2'd0, 16'h0002); rd(2'd0, d); chk("R3 clear", d, 16'h0000);

    // R4 set wins over clear
    ev_xfr_done = 1'b1;
    wr(2'd0, 16'h0002);
    ev_xfr_done = 1'b0;
    rd(2'd0, d); chk("R4 set wins", d, 16'h0002);

    // R10 irq falls one clock after clear
    wr(2'd1, 16'h2000);
    @(negedge clk);
    chk("R10 irq high", {15'b0, irq}, 16'h1);
    wr(2'd0, 16'h0002);
    chk("R10 irq lags", {15'b0, irq}, 16'h1);
    @(negedge clk);
    chk("R10 irq low", {15'b0, irq}, 16'h0);

    // R5 ready pin, rising edge
    wr(2'd1, 16'h0800);
    wr(2'd2, 16'h0012);
    rdy_pin = 1'b1;
    repeat (2) @(negedge clk);
    rd(2'd0, d); chk("R5 not before latency", d, 16'h0);
    @(negedge clk);
    rd(2'd0, d); chk("R5 rise latency", d, 16'h8000);
    @(negedge clk);
    chk("R10 rdy irq", {15'b0, irq}, 16'h1);
    wr(2'd0, 16'h8000);
    rdy_pin = 1'b0; settle();
    rd(2'd0, d); chk("R5 fall ignored", d, 16'h0);
    miso = 1'b1; settle(); miso = 1'b0; settle();
    rd(2'd0, d); chk("R5 miso ignored", d, 16'h0);
    // R5 falling polarity
    wr(2'd2, 16'h0002);
    rdy_pin = 1'b1; settle();
    rd(2'd0, d); chk("R5 rise ignored", d, 16'h0);
    rdy_pin = 1'b0; settle();
    rd(2'd0, d); chk("R5 fall set", d, 16'h8000);
    wr(2'd0, 16'h8000);

    // R6 MISO source
    wr(2'd2, 16'h0013);
    rdy_pin = 1'b1; settle(); rdy_pin = 1'b0; settle();
    rd(2'd0, d); chk("R6 rdy ignored", d, 16'h0);
    miso = 1'b1; settle();
    rd(2'd0, d); chk("R6 miso rise", d, 16'h8000);

    // R7 source off hides and clears the bit
    wr(2'd2, 16'h0011);
    rd(2'd0, d); chk("R7 off reads 0", d, 16'h0);
    miso = 1'b0; settle(); miso = 1'b1; settle();
    rdy_pin = 1'b1; settle();
    rd(2'd0, d); chk("R7 mode01", d, 16'h0);
    wr(2'd2, 16'h0010);
    rdy_pin = 1'b0; settle(); rdy_pin = 1'b1; settle();
    rd(2'd0, d); chk("R7 mode00", d, 16'h0);
    wr(2'd2, 16'h0013);
    rd(2'd0, d); chk("R7 no stale bit", d, 16'h0);
    wr(2'd2, 16'h0000);
    miso = 1'b0; rdy_pin = 1'b0; settle();

    // R8 chip-select edges
    wr(2'd1, 16'h0100);
    slave_mode = 1'b1; cont_mode = 1'b1;
    cs_n = 1'b0; settle();
    rd(2'd0, d); chk("R8 cs fall", d, 16'h4000);
    chk("R8 cs irq", {15'b0, irq}, 16'h1);
    wr(2'd0, 16'h4000);
    cs_n = 1'b1; settle();
    rd(2'd0, d); chk("R8 cs rise", d, 16'h2000);
    wr(2'd0, 16'h2000);
    cont_mode = 1'b0;
    cs_n = 1'b0; settle(); cs_n = 1'b1; settle();
    rd(2'd0, d); chk("R8 not continuous", d, 16'h0);
    cont_mode = 1'b1; slave_mode = 1'b0;
    cs_n = 1'b0; settle(); cs_n = 1'b1; settle();
    rd(2'd0, d); chk("R8 master", d, 16'h0);
    slave_mode = 1'b1; wr(2'd1, 16'h0000);
    cs_n = 1'b0; settle(); cs_n = 1'b1; settle();
    rd(2'd0, d); chk("R8 disabled", d, 16'h0);
    chk("R8 irq quiet", {15'b0, irq}, 16'h0);

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule